// File: doc/BRIEF.md
# Receive FIFO with Error Tracking

This block queues received characters between a serial receiver and a host. Each stored entry holds one character and the three line-error flags (parity, framing, break) the receiver attached to it. The flags stay with their character through the queue. The host sees the oldest character and the flags of that character, plus one bit that stays high while any stored character still carries an error.

A running count of flagged entries drives the summary bit. The host does not have to drain the whole queue to learn about an error further back. An overrun flag records characters that were dropped because no slot was free. Only a read of the line-status register clears it; emptying the queue does not. A synchronous flush input empties the queue and clears every flag. All outputs change on the clock edge that accepts the operation.

Top module: `rxq_err_fifo`

## Requirements
- R1: With the default depth of 64, `fill_level` gives the number of stored entries, from 0 to 64. An accepted write adds one. An accepted read removes one.
- R2: Characters leave in the order they were written. `head_char` shows the oldest stored character.
- R3: A write while 64 entries are stored and no read is asserted is discarded. The level stays at 64 and the head character and head flags do not change.
- R4: A discarded write sets `overrun`. `overrun` stays set through any number of reads and is cleared only by `status_rd`. If `status_rd` and a discarded write happen in the same cycle, `overrun` ends up set.
- R5: `head_brk`, `head_frm_err` and `head_par_err` show the break, framing and parity flags of the head entry. After each read they show the flags of the new head entry.
- R6: While the queue is empty, all three head flags read 0.
- R7: `err_in_queue` is 1 exactly when at least one stored entry has at least one flag set. It drops in the cycle after the last such entry is read.
- R8: A read and a write in the same cycle on a non-empty queue leave the level unchanged. `err_in_queue` then accounts for both the entry removed and the entry added.
- R9: A read while the queue is empty has no effect. The level stays 0.
- R10: `flush` empties the queue and clears `err_in_queue` and `overrun`. It takes priority over a write, a read or a status read in the same cycle.
- R11: After reset the level is 0, `overrun` is 0 and `err_in_queue` is 0.
- R12: A write to a full queue in the same cycle as a read is accepted. The level stays 64 and `overrun` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous queue clear |
| in_valid | input | 1 | Receiver offers a character this cycle |
| in_char | input | 8 | Received character |
| in_par_err | input | 1 | Parity error of the offered character |
| in_frm_err | input | 1 | Framing error of the offered character |
| in_brk | input | 1 | Break condition of the offered character |
| hold_rd | input | 1 | Host read of the holding register (pops the head) |
| status_rd | input | 1 | Host read of the line-status register |
| head_char | output | 8 | Oldest stored character |
| head_par_err | output | 1 | Parity flag of the head entry, 0 when empty |
| head_frm_err | output | 1 | Framing flag of the head entry, 0 when empty |
| head_brk | output | 1 | Break flag of the head entry, 0 when empty |
| err_in_queue | output | 1 | Some stored entry carries an error |
| overrun | output | 1 | A character was dropped because the queue was full |
| fill_level | output | 7 | Number of stored entries |

## Verification
Some properties are checked on every cycle. The error count never exceeds the fill level. A flagged head always implies the summary bit. A full queue refuses a lone write. A same-cycle read and write keeps the level. `overrun` holds until a status read, and flush leaves everything clear. What the bench scenarios alone can show is ordering and flag alignment across a wraparound of the storage. They also show that the summary bit drops on exactly the read that removes the last flagged entry. The bench compares every cycle of these scenarios against a queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] ch;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  rxq_entry_t    wr_entry,
  input  logic [AW-1:0] rd_addr,
  output rxq_entry_t    head
);
  rxq_entry_t mem [DEPTH];

  // plain synchronous-write array, read registered: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_entry;
  end

  // rd_addr is the head slot after this edge; forward a same-slot write
  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr == rd_addr)) head <= wr_entry;
    else                               head <= mem[rd_addr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          lsr_rd,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr_nxt,
  output logic [CW-1:0] level,
  output logic          overrun
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [AW-1:0] rd_ptr;
  logic          full;

  assign full  = (level == FULL_LVL);
  assign rd_ok = rd_req && (level != '0) && !flush;
  assign wr_ok = wr_req && !flush && (!full || rd_ok);

  always_comb begin
    if (rst || flush) rd_ptr_nxt = '0;
    else if (rd_ok)   rd_ptr_nxt = rd_ptr + AW'(1);
    else              rd_ptr_nxt = rd_ptr;
  end

  always_ff @(posedge clk) begin
    rd_ptr <= rd_ptr_nxt;
    if (rst || flush) wr_ptr <= '0;
    else if (wr_ok)   wr_ptr <= wr_ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) level <= '0;
    else begin
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush)          overrun <= 1'b0;
    else if (wr_req && !wr_ok) overrun <= 1'b1;
    else if (lsr_rd)           overrun <= 1'b0;
  end

  p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);

  p_full_discard_r3: assert property (@(posedge clk) disable iff (rst)
    full && wr_req && !rd_req && !flush |=> level == FULL_LVL && overrun);

  p_ovr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    overrun && !lsr_rd && !flush |=> overrun);

  p_rdwr_level_r8: assert property (@(posedge clk) disable iff (rst)
    wr_req && rd_req && level != '0 && !flush |=> $stable(level));

  p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
    level == '0 && rd_req && !wr_req |=> level == '0);
endmodule

// File: rtl/rxq_errtrk.sv
module rxq_errtrk #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_bad,
  input  logic          pop_bad,
  input  logic [CW-1:0] level,
  output logic          any_err
);
  logic [CW-1:0] err_cnt;
  logic [CW-1:0] err_nxt;

  always_comb begin
    err_nxt = err_cnt;
    if (push_bad) err_nxt = err_nxt + CW'(1);
    if (pop_bad)  err_nxt = err_nxt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      err_cnt <= '0;
      any_err <= 1'b0;
    end else begin
      err_cnt <= err_nxt;
      any_err <= (err_nxt != '0);
    end
  end

  // count of flagged entries can never exceed stored entries
  p_errcnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= level);

  // removing a flagged entry needs one on record
  p_pop_needs_err_r8: assert property (@(posedge clk) disable iff (rst)
    pop_bad && !flush |-> err_cnt != '0);
endmodule

// File: rtl/rxq_err_fifo.sv
module rxq_err_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       in_valid,
  input  logic [CHAR_W-1:0]          in_char,
  input  logic                       in_par_err,
  input  logic                       in_frm_err,
  input  logic                       in_brk,
  input  logic                       hold_rd,
  input  logic                       status_rd,
  output logic [CHAR_W-1:0]          head_char,
  output logic                       head_par_err,
  output logic                       head_frm_err,
  output logic                       head_brk,
  output logic                       err_in_queue,
  output logic                       overrun,
  output logic [$clog2(DEPTH):0]     fill_level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          wr_ok, rd_ok;
  logic [AW-1:0] wr_ptr, rd_ptr_nxt;
  logic [CW-1:0] level;
  rxq_entry_t    in_entry, head;
  logic          nonempty, push_bad, pop_bad;

  assign in_entry = '{brk: in_brk, frm: in_frm_err, par: in_par_err, ch: in_char};

  rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .wr_req     (in_valid),
    .rd_req     (hold_rd),
    .lsr_rd     (status_rd),
    .wr_ok      (wr_ok),
    .rd_ok      (rd_ok),
    .wr_ptr     (wr_ptr),
    .rd_ptr_nxt (rd_ptr_nxt),
    .level      (level),
    .overrun    (overrun)
  );

  rxq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk      (clk),
    .wr_en    (wr_ok),
    .wr_addr  (wr_ptr),
    .wr_entry (in_entry),
    .rd_addr  (rd_ptr_nxt),
    .head     (head)
  );

  assign push_bad = wr_ok && (in_brk || in_frm_err || in_par_err);
  assign pop_bad  = rd_ok && (head.brk || head.frm || head.par);

  rxq_errtrk #(.CW(CW)) u_err (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .push_bad (push_bad),
    .pop_bad  (pop_bad),
    .level    (level),
    .any_err  (err_in_queue)
  );

  assign nonempty     = (level != '0);
  assign fill_level   = level;
  assign head_char    = head.ch;
  assign head_par_err = head.par & nonempty;
  assign head_frm_err = head.frm & nonempty;
  assign head_brk     = head.brk & nonempty;

  // a flagged head entry is itself an error in the queue
  p_head_flag_any_r7: assert property (@(posedge clk) disable iff (rst)
    (head_par_err || head_frm_err || head_brk) |-> err_in_queue);

  p_flush_clear_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> fill_level == '0 && !err_in_queue && !overrun);

  p_empty_noerr_r7: assert property (@(posedge clk) disable iff (rst)
    fill_level == '0 |-> !err_in_queue);
endmodule

// File: tb/rxq_err_fifo_test.sv
module rxq_err_fifo_test;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst, flush, in_valid, in_par_err, in_frm_err, in_brk, hold_rd, status_rd;
  logic [7:0] in_char;
  logic [7:0] head_char;
  logic       head_par_err, head_frm_err, head_brk, err_in_queue, overrun;
  logic [6:0] fill_level;

  int checks = 0;
  int errors = 0;

  logic [10:0] mq [DEPTH];
  int mh = 0;
  int mc = 0;
  bit mo = 1'b0;

  always #5 clk = ~clk;

  rxq_err_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_char(in_char),
    .in_par_err(in_par_err), .in_frm_err(in_frm_err), .in_brk(in_brk),
    .hold_rd(hold_rd), .status_rd(status_rd), .head_char(head_char),
    .head_par_err(head_par_err), .head_frm_err(head_frm_err), .head_brk(head_brk),
    .err_in_queue(err_in_queue), .overrun(overrun), .fill_level(fill_level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_errs();
    int n = 0;
    for (int i = 0; i < mc; i++)
      if (mq[(mh + i) % DEPTH][10:8] != 3'b000) n++;
    return n;
  endfunction

  task automatic compare_all();
    logic [2:0] fl;
    logic [2:0] ef;
    fl = {head_brk, head_frm_err, head_par_err};
    chk(fill_level == mc, "R1 level", fill_level, mc);
    chk(overrun == mo, "R4 overrun", overrun, mo);
    chk(err_in_queue == (model_errs() != 0), "R7 summary", err_in_queue, model_errs() != 0);
    if (mc > 0) begin
      ef = mq[mh][10:8];
      chk(head_char == mq[mh][7:0], "R2 head char", head_char, mq[mh][7:0]);
      chk(fl == ef, "R5 head flags", fl, ef);
    end else begin
      chk(fl == 3'b000, "R6 empty flags", fl, 0);
    end
  endtask

  // flags argument: bit2 break, bit1 framing, bit0 parity
  task automatic cyc(input bit w, input logic [7:0] d, input logic [2:0] f,
                     input bit r, input bit l, input bit fz);
    bit rdok, wrok;
    in_valid = w; in_char = d; {in_brk, in_frm_err, in_par_err} = f;
    hold_rd = r; status_rd = l; flush = fz;
    if (fz) begin
      mc = 0; mh = 0; mo = 1'b0;
    end else begin
      rdok = r && (mc > 0);
      wrok = w && ((mc < DEPTH) || rdok);
      if (rdok) begin mh = (mh + 1) % DEPTH; mc--; end
      if (wrok) begin mq[(mh + mc) % DEPTH] = {f, d}; mc++; end
      if (w && !wrok) mo = 1'b1;
      else if (l)     mo = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; hold_rd = 0; status_rd = 0; flush = 0;
    compare_all();
  endtask

  function automatic logic [2:0] pat(input int i);
    return {(i % 11) == 3, (i % 7) == 2, (i % 5) == 1};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] hc;
    int lv;
    rst = 1; flush = 0; in_valid = 0; in_char = 0; in_par_err = 0; in_frm_err = 0;
    in_brk = 0; hold_rd = 0; status_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(fill_level == 0, "R11 level", fill_level, 0);
    chk(overrun == 0, "R11 overrun", overrun, 0);
    chk(err_in_queue == 0, "R11 summary", err_in_queue, 0);

    // R9 read on empty is ignored
    cyc(0, 0, 0, 1, 0, 0);
    chk(fill_level == 0, "R9 empty read", fill_level, 0);

    // fill to 64 with varied flags
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i * 7 + 3), pat(i), 0, 0, 0);

    // R3 lone write to full is dropped
    hc = head_char;
    cyc(1, 8'hEE, 3'b100, 0, 0, 0);
    chk(fill_level == DEPTH, "R3 level kept", fill_level, DEPTH);
    chk(head_char == hc, "R3 head kept", head_char, hc);
    chk(overrun == 1, "R4 set", overrun, 1);

    // R4 reads do not clear overrun
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0, 0);
    chk(overrun == 1, "R4 held over reads", overrun, 1);
    cyc(0, 0, 0, 0, 1, 0);
    chk(overrun == 0, "R4 status read clears", overrun, 0);

    // R12 refill then write with read at full
    for (int i = 0; i < 4; i++) cyc(1, 8'(200 + i), pat(i + 2), 0, 0, 0);
    cyc(1, 8'h5A, 3'b001, 1, 0, 0);
    chk(fill_level == DEPTH, "R12 level", fill_level, DEPTH);
    chk(overrun == 0, "R12 no overrun", overrun, 0);

    // R4 overflow and status read together: set wins
    cyc(1, 8'h11, 3'b000, 0, 1, 0);
    chk(overrun == 1, "R4 set wins", overrun, 1);
    cyc(0, 0, 0, 0, 1, 0);

    // drain fully: summary must drop on last flagged read (R7)
    while (mc > 0) cyc(0, 0, 0, 1, 0, 0);
    chk(err_in_queue == 0, "R7 drained", err_in_queue, 0);

    // R8 simultaneous read and write on a short queue
    for (int i = 0; i < 3; i++) cyc(1, 8'(40 + i), pat(i), 0, 0, 0);
    for (int i = 0; i < 20; i++) begin
      lv = fill_level;
      cyc(1, 8'(90 + i), pat(i * 3), 1, 0, 0);
      chk(fill_level == lv, "R8 level", fill_level, lv);
    end

    // R10 flush beats write, read and status read
    cyc(1, 8'h77, 3'b111, 1, 1, 1);
    chk(fill_level == 0, "R10 level", fill_level, 0);
    chk(err_in_queue == 0, "R10 summary", err_in_queue, 0);

    // sweep with mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int rv;
      rv = $urandom % 100;
      cyc(rv < 55, 8'($urandom), 3'($urandom % 8 < 3 ? $urandom : 0),
          ($urandom % 100) < 45, ($urandom % 100) < 5, ($urandom % 1000) < 4);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule